// File: doc/BRIEF.md
# Mailbox Receive Queue

This block is the receive side of a processor-to-processor mailbox. Messages from other cores arrive on a valid/ready push port. Each message has a 64-bit payload and a sender identifier. The block keeps them in a circular queue of `DEPTH` entries. The local processor sees the oldest entry through three read registers: sender, lower payload word and upper payload word. It then writes a pop register to retire that entry.

Software works out how full the queue is from a status register. That register shows the raw read index, the raw write index and a full flag. With equal indices the flag tells full from empty. Otherwise the count is write minus read, or `DEPTH` minus read plus write once the write index has wrapped. A pending bit records that the queue held data. Software clears it by writing a one, and a mask decides whether it drives the interrupt line.

Top module: `mbox_rx_fifo`

## Requirements
- R1: A push is accepted when `in_valid` and `in_ready` are both high at a clock edge. The entry is stored at the write index, which then advances by one modulo `DEPTH`. `in_ready` is low exactly while the queue is full, and a push offered then changes nothing.
- R2: Reads of the oldest entry:
  - offset 0x00 returns its sender ID, zero-extended;
  - offset 0x04 returns payload bits 31:0;
  - offset 0x08 returns payload bits 63:32.
- R3: Writing a value with bit 0 set to offset 0x0C retires the oldest entry and advances the read index modulo `DEPTH`. On an empty queue the write has no effect.
- R4: Offset 0x14 reads the read index in bits 31:24, the write index in bits 23:16 and the full flag in bit 2. All other bits read 0. Equal indices with the flag clear mean empty.
- R5: Offset 0x24 reads `DEPTH`-1.
- R6: Writing exactly 0 to offset 0x10 clears both indices and the full flag. This takes priority over a push in the same cycle. A non-zero write to 0x10 has no effect.
- R7: Bit 0 of offset 0x18 is the pending bit:
  - it is 0 after reset;
  - it becomes 1 on the edge after any cycle in which the queue holds data;
  - writing a value with bit 0 set clears it;
  - it sets again one cycle later if data remains.
- R8: Offset 0x1C holds a 5-bit mask, read in bits 4:0, that resets to 0x1F. `irq` equals the pending bit AND NOT mask bit 0.
- R9: Entries leave in the order they arrived, including across index wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Incoming message valid |
| in_ready | output | 1 | Queue can take a message |
| in_id | input | ID_W | Sender identifier |
| in_data | input | 64 | Message payload |
| reg_addr | input | 6 | Register byte offset |
| reg_wen | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Not-empty interrupt |

## Verification
A corrupted read or write index shows up in the status word on the cycle after the edge that corrupted it. It also shows up in the head registers as a wrong or reordered message. A wrong full flag appears at once on `in_ready`, or as a lost or overwritten entry once the queue is filled and drained across the wrap point. A faulty pending bit shows on `irq` one cycle after a push or a clear, which is when the bench samples it.

// File: rtl/mbox_rx_fifo.sv
module mbox_rx_fifo #(
  parameter int DEPTH = 8,
  parameter int ID_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [ID_W-1:0]  in_id,
  input  logic [63:0]      in_data,
  input  logic [5:0]       reg_addr,
  input  logic             reg_wen,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             irq
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [ID_W+63:0] mem [DEPTH];
  logic [AW-1:0]    rd_ptr, wr_ptr, rd_nxt, wr_nxt;
  logic             full, pend;
  logic [4:0]       mask;

  wire empty   = (rd_ptr == wr_ptr) && !full;
  wire push    = in_valid && in_ready;
  wire clr_q   = reg_wen && (reg_addr == 6'h10) && (reg_wdata == 32'd0);
  wire pop     = reg_wen && (reg_addr == 6'h0C) && reg_wdata[0] && !empty;
  wire clr_irq = reg_wen && (reg_addr == 6'h18) && reg_wdata[0];
  wire [ID_W+63:0] head = mem[rd_ptr];

  assign rd_nxt   = (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
  assign wr_nxt   = (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
  assign in_ready = !full;
  assign irq      = pend && !mask[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      full   <= 1'b0;
    end else if (clr_q) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      full   <= 1'b0;
    end else begin
      if (push) wr_ptr <= wr_nxt;
      if (pop)  rd_ptr <= rd_nxt;
      if (push && !pop && (wr_nxt == rd_ptr)) full <= 1'b1;
      else if (pop && !push)                  full <= 1'b0;
    end
  end

  always_ff @(posedge clk)
    if (push && !clr_q) mem[wr_ptr] <= {in_id, in_data};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      mask <= 5'h1F;
    end else begin
      if (clr_irq)     pend <= 1'b0;
      else if (!empty) pend <= 1'b1;
      if (reg_wen && reg_addr == 6'h1C) mask <= reg_wdata[4:0];
    end
  end

  always_comb begin
    case (reg_addr)
      6'h00:   reg_rdata = 32'(head[ID_W+63:64]);
      6'h04:   reg_rdata = head[31:0];
      6'h08:   reg_rdata = head[63:32];
      6'h14:   reg_rdata = {8'(rd_ptr), 8'(wr_ptr), 13'd0, full, 2'b00};
      6'h18:   reg_rdata = {31'd0, pend};
      6'h1C:   reg_rdata = {27'd0, mask};
      6'h24:   reg_rdata = 32'(DEPTH - 1);
      default: reg_rdata = 32'd0;
    endcase
  end

  assert_full_blocks_push_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop && !clr_q) |=> $stable(wr_ptr));
  assert_empty_pop_noop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && reg_wen && reg_addr == 6'h0C && !push && !clr_q) |=> $stable(rd_ptr));
  assert_queue_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_q |=> (rd_ptr == '0 && wr_ptr == '0 && !full));
  assert_pending_resets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty && !clr_irq) |=> pend);
  assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> !mask[0]);
endmodule

// File: tb/mbox_rx_fifo_tb.sv
module mbox_rx_fifo_tb;
  localparam int DEPTH = 8;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_ready;
  logic [7:0] in_id = 0;
  logic [63:0] in_data = 0;
  logic [5:0] reg_addr = 0;
  logic reg_wen = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic irq;
  int vecs = 0, bad = 0;

  mbox_rx_fifo #(.DEPTH(DEPTH), .ID_W(8)) u_dut (.*);

  always #5 clk = ~clk;

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    vecs++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] v);
    reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wen = 1;
    tick();
    reg_wen = 0;
  endtask

  task automatic push(input logic [7:0] id, input logic [63:0] d);
    in_valid = 1; in_id = id; in_data = d;
    tick();
    in_valid = 0;
  endtask

  function automatic logic [31:0] sts(int r, int w, bit f);
    return {8'(r), 8'(w), 13'd0, f, 2'b00};
  endfunction

  function automatic logic [63:0] pat(int i);
    return {32'hA000_0000 + 32'(i), 32'h0000_5000 + 32'(i * 3)};
  endfunction

  logic [31:0] v;

  task automatic t_reset();
    rd(6'h14, v); check("R4 reset status", v, 0);
    rd(6'h24, v); check("R5 depth", v, DEPTH - 1);
    rd(6'h1C, v); check("R8 mask reset", v, 32'h1F);
    rd(6'h18, v); check("R7 pending reset", v, 0);
    check("R1 ready at reset", in_ready, 1);
  endtask

  task automatic t_push_read();
    push(8'h3C, 64'h1111_2222_3333_4444);
    rd(6'h00, v); check("R2 head id", v, 32'h3C);
    rd(6'h04, v); check("R2 head low", v, 32'h3333_4444);
    rd(6'h08, v); check("R2 head high", v, 32'h1111_2222);
    rd(6'h14, v); check("R1 write index advance", v, sts(0, 1, 0));
  endtask

  task automatic t_irq();
    tick();
    rd(6'h18, v); check("R7 pending set", v, 1);
    check("R8 masked irq", irq, 0);
    wr(6'h1C, 32'h1E);
    check("R8 unmasked irq", irq, 1);
    wr(6'h18, 32'h1);
    rd(6'h18, v); check("R7 cleared", v, 0);
    tick();
    rd(6'h18, v); check("R7 re-set while data remains", v, 1);
    check("R8 irq follows pending", irq, 1);
  endtask

  task automatic t_pop();
    wr(6'h0C, 32'h1);
    rd(6'h14, v); check("R3 pop advances read index", v, sts(1, 1, 0));
    wr(6'h0C, 32'h1);
    rd(6'h14, v); check("R3 pop on empty ignored", v, sts(1, 1, 0));
    wr(6'h18, 32'h1);
    tick();
    rd(6'h18, v); check("R7 stays clear when empty", v, 0);
    check("R8 irq low", irq, 0);
  endtask

  task automatic t_fill_wrap();
    for (int i = 0; i < DEPTH; i++) push(8'(i + 1), pat(i));
    rd(6'h14, v); check("R4 full status", v, sts(1, 1, 1));
    check("R1 ready low when full", in_ready, 0);
    push(8'hEE, 64'hDEAD_BEEF_DEAD_BEEF);
    rd(6'h14, v); check("R1 push while full ignored", v, sts(1, 1, 1));
    for (int i = 0; i < DEPTH; i++) begin
      rd(6'h00, v); check("R9 order id", v, 32'(i + 1));
      rd(6'h04, v); check("R9 order low", v, pat(i)[31:0]);
      rd(6'h08, v); check("R9 order high", v, pat(i)[63:32]);
      wr(6'h0C, 32'h1);
    end
    rd(6'h14, v); check("R4 empty after wrap", v, sts(1, 1, 0));
    check("R1 ready after drain", in_ready, 1);
  endtask

  task automatic t_clear();
    push(8'h01, 64'h1);
    push(8'h02, 64'h2);
    wr(6'h10, 32'h5);
    rd(6'h14, v); check("R6 non-zero write ignored", v, sts(1, 3, 0));
    wr(6'h10, 32'h0);
    rd(6'h14, v); check("R6 clear", v, 0);
    in_valid = 1; in_id = 8'h9; in_data = 64'h9;
    wr(6'h10, 32'h0);
    in_valid = 0;
    rd(6'h14, v); check("R6 clear beats push", v, 0);
  endtask

  initial begin
    #1000000;
    bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    #12 rst_n = 1;
    @(negedge clk);
    t_reset();
    t_push_read();
    t_irq();
    t_pop();
    t_fill_wrap();
    t_clear();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule